// File: doc/BRIEF.md
# Link receive packet dispatcher

This block sits in one port of a packet switch, right after packet reception. Each cycle it may be handed one received packet. The packet arrives with its kind, its storage address, a destination field, a sequence number, and two integrity flags. One flag covers transaction packets and the other covers link-control packets. The block judges the packet and reports a two-bit status made of a valid flag and an is-transaction flag. It then hands the packet's storage address onward.

A good transaction packet is looked up in a small per-port routing table. Its address is written into one of two send queues that feed the other ports. Every transaction packet, good or bad, also yields an acknowledge-queue entry. The entry carries a negative-acknowledge bit that is set when the packet failed its check. Link-control packets are passed, with their address and status, to the replay control logic.

The routing table is written through its own port, normally once after reset, before traffic starts. All outputs are registered. They appear one clock after the packet is presented, as single-cycle pulses.

Top module: `rx_dispatch`

## Requirements
- R1: While `rst_n` is low, every output is 0. After reset every routing-table entry is empty.
- R2: Status appears one cycle after `pkt_valid`. The kind is encoded as `pkt_kind` 2'b01 for transaction and 2'b10 for link-control. The status is {`st_valid`,`st_tlp`}: 11 means good transaction, 10 good link-control, 01 bad transaction, and 00 bad link-control or an unrecognized kind (2'b00 or 2'b11). An unrecognized kind produces no other output.
- R3: A transaction packet is judged only by `pkt_tlp_crc_ok`. A link-control packet is judged only by `pkt_lc_crc_ok`.
- R4: A good transaction packet whose destination entry is present pulses `sq1_en` when the entry's select is 0, or `sq2_en` when it is 1. It never pulses both. `sq_addr` then equals the packet's `pkt_addr`.
- R5: A good transaction packet whose destination entry is empty pulses `drop` and asserts no queue enable.
- R6: A bad transaction packet pulses neither queue enable nor `drop`.
- R7: Every transaction packet pulses `ack_en`. `ack_entry` is {nak, `pkt_seq`}, with the nak bit at position SEQ_W set to the inverse of the packet's validity (1 means negative acknowledge).
- R8: Every link-control packet pulses `rc_en`, with `rc_addr` equal to `pkt_addr` and `rc_ok` equal to its integrity flag. It pulses no `ack_en` and no queue enable.
- R9: A write with `rt_we` sets entry `rt_idx` present, with select `rt_qsel`. A packet presented in the same cycle as the write still sees the table as it was before the write.
- R10: When no packet is presented, all status and enable outputs read 0 the next cycle. A packet therefore causes each enable for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | A received packet is presented this cycle |
| pkt_kind | input | 2 | 01 transaction, 10 link-control, other unrecognized |
| pkt_tlp_crc_ok | input | 1 | Integrity result for a transaction packet |
| pkt_lc_crc_ok | input | 1 | Integrity result for a link-control packet |
| pkt_addr | input | ADDR_W | Storage address of the packet |
| pkt_dest | input | DEST_W | Destination field used for table lookup |
| pkt_seq | input | SEQ_W | Sequence number of the packet |
| rt_we | input | 1 | Routing-table write strobe |
| rt_idx | input | DEST_W | Routing-table entry being written |
| rt_qsel | input | 1 | Queue select for the entry (0 first, 1 second) |
| st_valid | output | 1 | Status: packet passed its check |
| st_tlp | output | 1 | Status: packet is a transaction packet |
| sq1_en | output | 1 | Write pulse to the first send queue |
| sq2_en | output | 1 | Write pulse to the second send queue |
| sq_addr | output | ADDR_W | Address written to a send queue |
| drop | output | 1 | Good transaction packet had no table entry |
| ack_en | output | 1 | Write pulse to the acknowledge queue |
| ack_entry | output | SEQ_W+1 | Acknowledge entry, nak bit on top |
| rc_en | output | 1 | Link-control packet forwarded to replay control |
| rc_addr | output | ADDR_W | Address of the forwarded link-control packet |
| rc_ok | output | 1 | Integrity result of the forwarded packet |

## Verification
The hardest situation to reach is a table write and a lookup of the same entry in one cycle. Here the packet must be routed on the old contents, and only the next one on the new. The bench aims a directed pair at an entry that is empty at first: the first packet must drop and the one after it must land in the second queue. Random traffic then mixes table rewrites with packets of all four kinds and both integrity outcomes. This exercises misses, negative acknowledges and back-to-back pulses in many orders.

// File: rtl/rx_dispatch.sv
module rx_dispatch #(
  parameter int ADDR_W = 12,
  parameter int DEST_W = 4,
  parameter int SEQ_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid,
  input  logic [1:0]        pkt_kind,
  input  logic              pkt_tlp_crc_ok,
  input  logic              pkt_lc_crc_ok,
  input  logic [ADDR_W-1:0] pkt_addr,
  input  logic [DEST_W-1:0] pkt_dest,
  input  logic [SEQ_W-1:0]  pkt_seq,
  input  logic              rt_we,
  input  logic [DEST_W-1:0] rt_idx,
  input  logic              rt_qsel,
  output logic              st_valid,
  output logic              st_tlp,
  output logic              sq1_en,
  output logic              sq2_en,
  output logic [ADDR_W-1:0] sq_addr,
  output logic              drop,
  output logic              ack_en,
  output logic [SEQ_W:0]    ack_entry,
  output logic              rc_en,
  output logic [ADDR_W-1:0] rc_addr,
  output logic              rc_ok
);
  localparam int ENTRIES = 1 << DEST_W;
  localparam logic [1:0] KIND_TXN = 2'b01;
  localparam logic [1:0] KIND_LNK = 2'b10;

  logic [ENTRIES-1:0] map_hit, map_q2;
  logic [ADDR_W-1:0]  addr_q;
  logic is_txn, is_lnk, crc_good, route_ok, hit, to_q2;

  assign is_txn   = pkt_valid && (pkt_kind == KIND_TXN);
  assign is_lnk   = pkt_valid && (pkt_kind == KIND_LNK);
  assign crc_good = (is_txn && pkt_tlp_crc_ok) || (is_lnk && pkt_lc_crc_ok);
  assign route_ok = is_txn && pkt_tlp_crc_ok;
  assign hit      = map_hit[pkt_dest];
  assign to_q2    = map_q2[pkt_dest];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_hit <= '0;
      map_q2  <= '0;
    end else if (rt_we) begin
      map_hit[rt_idx] <= 1'b1;
      map_q2[rt_idx]  <= rt_qsel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_valid  <= 1'b0;
      st_tlp    <= 1'b0;
      sq1_en    <= 1'b0;
      sq2_en    <= 1'b0;
      drop      <= 1'b0;
      ack_en    <= 1'b0;
      ack_entry <= '0;
      rc_en     <= 1'b0;
      rc_ok     <= 1'b0;
      addr_q    <= '0;
    end else begin
      st_valid  <= crc_good;
      st_tlp    <= is_txn;
      sq1_en    <= route_ok && hit && !to_q2;
      sq2_en    <= route_ok && hit && to_q2;
      drop      <= route_ok && !hit;
      ack_en    <= is_txn;
      ack_entry <= is_txn ? {!pkt_tlp_crc_ok, pkt_seq} : '0;
      rc_en     <= is_lnk;
      rc_ok     <= is_lnk && pkt_lc_crc_ok;
      addr_q    <= pkt_valid ? pkt_addr : '0;
    end
  end

  assign sq_addr = addr_q;
  assign rc_addr = addr_q;
endmodule

// File: rtl/rx_dispatch_chk.sv
module rx_dispatch_chk #(
  parameter int SEQ_W = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pkt_valid,
  input logic [1:0]     pkt_kind,
  input logic           st_valid,
  input logic           st_tlp,
  input logic           sq1_en,
  input logic           sq2_en,
  input logic           drop,
  input logic           ack_en,
  input logic [SEQ_W:0] ack_entry,
  input logic           rc_en,
  input logic           rc_ok
);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |=> !st_valid && !st_tlp && !sq1_en && !sq2_en && !drop && !ack_en && !rc_en);

  a_r7_ack_every_txn: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_kind == 2'b01) |=> ack_en && st_tlp);

  a_r8_lnk_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_kind == 2'b10) |=> rc_en && !ack_en && !sq1_en && !sq2_en);

  a_r4_one_queue: assert property (@(posedge clk) disable iff (!rst_n)
    !(sq1_en && sq2_en));

  a_r6_route_needs_good: assert property (@(posedge clk) disable iff (!rst_n)
    (sq1_en || sq2_en || drop) |-> (st_valid && st_tlp && ack_en));

  a_r7_nak_bit: assert property (@(posedge clk) disable iff (!rst_n)
    ack_en |-> (ack_entry[SEQ_W] == !st_valid));

  a_r8_rc_status: assert property (@(posedge clk) disable iff (!rst_n)
    rc_en |-> (rc_ok == st_valid) && !st_tlp);
endmodule

bind rx_dispatch rx_dispatch_chk #(.SEQ_W(SEQ_W)) u_chk (.*);

// File: tb/tb_rx_dispatch.sv
module tb_rx_dispatch;
  localparam int ADDR_W = 12;
  localparam int DEST_W = 4;
  localparam int SEQ_W  = 12;
  localparam int ENTRIES = 1 << DEST_W;

  logic clk = 1'b0;
  logic rst_n;
  logic pkt_valid, pkt_tlp_crc_ok, pkt_lc_crc_ok, rt_we, rt_qsel;
  logic [1:0] pkt_kind;
  logic [ADDR_W-1:0] pkt_addr;
  logic [DEST_W-1:0] pkt_dest, rt_idx;
  logic [SEQ_W-1:0] pkt_seq;
  logic st_valid, st_tlp, sq1_en, sq2_en, drop, ack_en, rc_en, rc_ok;
  logic [ADDR_W-1:0] sq_addr, rc_addr;
  logic [SEQ_W:0] ack_entry;

  int n_cmp = 0;
  int n_bad = 0;
  logic [ENTRIES-1:0] m_hit, m_q2;

  logic e_stv, e_stt, e_sq1, e_sq2, e_drop, e_ack, e_rc, e_rcok;
  logic [SEQ_W:0] e_entry;
  logic [ADDR_W-1:0] e_addr;

  always #5 clk = ~clk;

  rx_dispatch dut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_kind(pkt_kind),
    .pkt_tlp_crc_ok(pkt_tlp_crc_ok), .pkt_lc_crc_ok(pkt_lc_crc_ok),
    .pkt_addr(pkt_addr), .pkt_dest(pkt_dest), .pkt_seq(pkt_seq),
    .rt_we(rt_we), .rt_idx(rt_idx), .rt_qsel(rt_qsel),
    .st_valid(st_valid), .st_tlp(st_tlp), .sq1_en(sq1_en), .sq2_en(sq2_en),
    .sq_addr(sq_addr), .drop(drop), .ack_en(ack_en), .ack_entry(ack_entry),
    .rc_en(rc_en), .rc_addr(rc_addr), .rc_ok(rc_ok)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [SEQ_W:0] ack_model(input logic ok, input logic [SEQ_W-1:0] seq);
    return {~ok, seq};
  endfunction

  task automatic step(input logic v, input logic [1:0] kind, input logic tc, input logic lc,
                      input logic [ADDR_W-1:0] addr, input logic [DEST_W-1:0] dest,
                      input logic [SEQ_W-1:0] seq, input logic we,
                      input logic [DEST_W-1:0] idx, input logic qs);
    logic txn, lnk;
    pkt_valid = v; pkt_kind = kind; pkt_tlp_crc_ok = tc; pkt_lc_crc_ok = lc;
    pkt_addr = addr; pkt_dest = dest; pkt_seq = seq;
    rt_we = we; rt_idx = idx; rt_qsel = qs;
    txn = v && kind == 2'b01;
    lnk = v && kind == 2'b10;
    e_stv   = (txn && tc) || (lnk && lc);
    e_stt   = txn;
    e_sq1   = txn && tc && m_hit[dest] && !m_q2[dest];
    e_sq2   = txn && tc && m_hit[dest] && m_q2[dest];
    e_drop  = txn && tc && !m_hit[dest];
    e_ack   = txn;
    e_entry = ack_model(tc, seq);
    e_rc    = lnk;
    e_rcok  = lnk && lc;
    e_addr  = addr;
    if (we) begin
      m_hit[idx] = 1'b1;
      m_q2[idx]  = qs;
    end
    @(posedge clk);
    @(negedge clk);
    check("R2 R3 status", {30'd0, st_valid, st_tlp}, {30'd0, e_stv, e_stt});
    check("R4 R6 R9 queue enables", {30'd0, sq1_en, sq2_en}, {30'd0, e_sq1, e_sq2});
    if (e_sq1 || e_sq2) check("R4 queue address", 32'(sq_addr), 32'(e_addr));
    check("R5 R6 drop", 32'(drop), 32'(e_drop));
    check("R7 ack enable", 32'(ack_en), 32'(e_ack));
    if (e_ack) check("R7 ack entry", 32'(ack_entry), 32'(e_entry));
    check("R8 replay forward", {30'd0, rc_en, rc_ok}, {30'd0, e_rc, e_rcok});
    if (e_rc) check("R8 replay address", 32'(rc_addr), 32'(e_addr));
    if (!v) check("R10 quiet when idle",
                  {25'd0, st_valid, st_tlp, sq1_en, sq2_en, drop, ack_en, rc_en}, 32'd0);
  endtask

  task automatic idle();
    step(1'b0, 2'b00, 1'b0, 1'b0, '0, '0, '0, 1'b0, '0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    m_hit = '0; m_q2 = '0;
    rst_n = 1'b0;
    pkt_valid = 1'b1; pkt_kind = 2'b01; pkt_tlp_crc_ok = 1'b1; pkt_lc_crc_ok = 1'b1;
    pkt_addr = '1; pkt_dest = '0; pkt_seq = '1; rt_we = 1'b0; rt_idx = '0; rt_qsel = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 outputs in reset",
          {22'd0, st_valid, st_tlp, sq1_en, sq2_en, drop, ack_en, rc_en, rc_ok,
           |sq_addr, |ack_entry}, 32'd0);
    rst_n = 1'b1;

    // R1: empty table after reset, good transaction drops
    step(1'b1, 2'b01, 1'b1, 1'b0, 12'h0a1, 4'd0, 12'h001, 1'b0, '0, 1'b0);

    for (int i = 0; i < 12; i++)
      step(1'b0, 2'b00, 1'b0, 1'b0, '0, '0, '0, 1'b1, DEST_W'(i), i[0]);

    step(1'b1, 2'b01, 1'b1, 1'b0, 12'h111, 4'd0, 12'h010, 1'b0, '0, 1'b0);
    step(1'b1, 2'b01, 1'b1, 1'b1, 12'h222, 4'd1, 12'h011, 1'b0, '0, 1'b0);
    step(1'b1, 2'b01, 1'b1, 1'b0, 12'h333, 4'd13, 12'h012, 1'b0, '0, 1'b0);
    step(1'b1, 2'b01, 1'b0, 1'b1, 12'h444, 4'd0, 12'h013, 1'b0, '0, 1'b0);
    step(1'b1, 2'b01, 1'b0, 1'b1, 12'h445, 4'd13, 12'h014, 1'b0, '0, 1'b0);
    step(1'b1, 2'b10, 1'b0, 1'b1, 12'h555, 4'd2, 12'h015, 1'b0, '0, 1'b0);
    step(1'b1, 2'b10, 1'b1, 1'b0, 12'h666, 4'd2, 12'h016, 1'b0, '0, 1'b0);
    step(1'b1, 2'b00, 1'b1, 1'b1, 12'h777, 4'd0, 12'h017, 1'b0, '0, 1'b0);
    step(1'b1, 2'b11, 1'b1, 1'b1, 12'h888, 4'd1, 12'h018, 1'b0, '0, 1'b0);
    idle();
    // R9: write and lookup of entry 14 in the same cycle
    step(1'b1, 2'b01, 1'b1, 1'b0, 12'h999, 4'd14, 12'h019, 1'b1, 4'd14, 1'b1);
    step(1'b1, 2'b01, 1'b1, 1'b0, 12'h99a, 4'd14, 12'h01a, 1'b0, '0, 1'b0);
    // R9: rewrite select of entry 0
    step(1'b0, 2'b00, 1'b0, 1'b0, '0, '0, '0, 1'b1, 4'd0, 1'b1);
    step(1'b1, 2'b01, 1'b1, 1'b0, 12'habc, 4'd0, 12'h01b, 1'b0, '0, 1'b0);
    idle();

    for (int n = 0; n < 600; n++) begin
      logic v, we;
      v  = ($urandom % 4) != 0;
      we = ($urandom % 16) == 0;
      step(v, 2'($urandom), 1'($urandom), 1'($urandom), ADDR_W'($urandom),
           DEST_W'($urandom), SEQ_W'($urandom), we, DEST_W'($urandom), 1'($urandom));
    end
    idle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule